// File: doc/BRIEF.md
# Masked-write interrupt request and enable unit

This block collects six single-cycle event pulses (timer, transmit done, receive done, idle, FIFO high alert, FIFO low alert) into a sticky request register, gates them with an enable register and drives one interrupt pin. Software never loads either register outright. Bit 7 of each written byte chooses whether the bits written as 1 in the low six positions are set or cleared. Every other bit keeps its value, so one agent can acknowledge a single source without a read-modify-write.

A small configuration register shapes the pin. One bit picks the polarity. The other picks push-pull drive or an open-drain style drive, which is modelled with an output-enable signal. Register reads are combinational from a separate read address.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset the request and enable registers read 00h, the configuration register reads 02h, irq_o is 0 and irq_oe is 0.
- R2: An event pulse on evt[i] sets request bit i from the next cycle on. The bit stays set after the pulse ends until a clear write removes it. The bit map is: 5 timer, 4 transmit, 3 receive, 2 idle, 1 high alert, 0 low alert.
- R3: A write to the request register (address 0) with bit 7 = 0 clears each request bit whose data bit in 5:0 is 1 and leaves the rest unchanged. Writing 3Fh clears all six.
- R4: A write to the request register with bit 7 = 1 sets each request bit whose data bit in 5:0 is 1 and leaves the rest unchanged. Writing 81h sets only bit 0.
- R5: The enable register (address 1) uses the same bit map and the same set/clear rule as R3 and R4.
- R6: When an event pulse and a clear write hit the same request bit in the same cycle, the bit ends up set.
- R7: The pending signal is the OR over all i of request[i] AND enable[i]. Configuration bit 1 = 1 makes irq_o equal to pending. Configuration bit 1 = 0 makes irq_o equal to NOT pending.
- R8: Configuration bit 0 = 1 (push-pull) holds irq_oe at 1. Configuration bit 0 = 0 (open-drain style) makes irq_oe equal to pending.
- R9: Reads return the register in the low bits with all upper bits 0. Address 0 gives the request bits in 5:0, address 1 gives the enable bits in 5:0, address 2 gives the configuration bits in 1:0, and address 3 reads 00h. Configuration writes load bits 1:0 directly.
- R10: Bit 6 of a written byte has no effect, and a write to one register leaves the other two unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 request, 1 enable, 2 configuration) |
| wr_data | input | 8 | Write data; bit 7 selects set or clear for addresses 0 and 1 |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| evt | input | 6 | Event pulses, one per source |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and six sources. This makes every bit of the set/clear mask, the ignored bit 6 and all four polarity and drive combinations reachable. A behavioural model tracks the three registers and the pin on every clock. Directed steps cover the corners: clearing all six sources at once, and an event colliding with a clear of the same bit. Long random write and event traffic then exercises overlapping set, clear and enable changes.

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter int DW   = 8,
  parameter int NSRC = 6,
  parameter int AW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [NSRC-1:0] evt,
  output logic          irq_o,
  output logic          irq_oe
);
  localparam logic [AW-1:0] A_REQ = AW'(0);
  localparam logic [AW-1:0] A_EN  = AW'(1);
  localparam logic [AW-1:0] A_CFG = AW'(2);
  localparam logic [1:0]    CFG_RST = 2'b10;

  logic [NSRC-1:0] req_q, en_q;
  logic [1:0]      cfg_q;
  logic [NSRC-1:0] mask;
  logic            set_op, wr_req, wr_en_reg, wr_cfg, pending;

  assign mask      = wr_data[NSRC-1:0];
  assign set_op    = wr_data[DW-1];
  assign wr_req    = wr_en && (wr_addr == A_REQ);
  assign wr_en_reg = wr_en && (wr_addr == A_EN);
  assign wr_cfg    = wr_en && (wr_addr == A_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      en_q  <= '0;
      cfg_q <= CFG_RST;
    end else begin
      if (wr_req)
        req_q <= (set_op ? (req_q | mask) : (req_q & ~mask)) | evt;
      else
        req_q <= req_q | evt;
      if (wr_en_reg)
        en_q <= set_op ? (en_q | mask) : (en_q & ~mask);
      if (wr_cfg)
        cfg_q <= wr_data[1:0];
    end
  end

  assign pending = |(req_q & en_q);
  assign irq_o   = cfg_q[1] ? pending : ~pending;
  assign irq_oe  = cfg_q[0] | pending;

  always_comb begin
    case (rd_addr)
      A_REQ:   rd_data = {{(DW-NSRC){1'b0}}, req_q};
      A_EN:    rd_data = {{(DW-NSRC){1'b0}}, en_q};
      A_CFG:   rd_data = {{(DW-2){1'b0}}, cfg_q};
      default: rd_data = '0;
    endcase
  end

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((req_q & $past(evt)) == $past(evt))); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && evt == '0) |=> $stable(req_q)); // R2
  AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !set_op && evt == '0) |=> ((req_q & $past(mask)) == '0)); // R3
  AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && set_op) |=> ((req_q & $past(mask)) == $past(mask))); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_reg) |=> $stable(en_q)); // R5
  AST_PP_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_CFG && rd_data[0]) |-> irq_oe); // R8
endmodule

// File: tb/irq_mask_unit_bench.sv
module irq_mask_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] evt = '0;
  logic       irq_o, irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_req = 0, m_en = 0, m_cfg = 2;

  irq_mask_unit u_irq_mask_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt(evt), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int apply_mask(input int cur, input int d);
    int r = cur;
    for (int i = 0; i < 6; i++)
      if ((d >> i) & 1) begin
        if ((d >> 7) & 1) r = r | (1 << i);
        else r = r & ~(1 << i);
      end
    return r;
  endfunction

  task automatic pin_chk();
    int pend = ((m_req & m_en) != 0) ? 1 : 0;
    int lvl = ((m_cfg >> 1) & 1) ? pend : 1 - pend;
    int oe = ((m_cfg & 1) != 0 || pend != 0) ? 1 : 0;
    chk("R7 irq_o", int'(irq_o), lvl);
    chk("R8 irq_oe", int'(irq_oe), oe);
  endtask

  task automatic step(input bit we, input int a, input int d, input int e);
    @(negedge clk);
    wr_en = we; wr_addr = a[1:0]; wr_data = d[7:0]; evt = e[5:0];
    @(posedge clk);
    if (we) begin
      if (a == 0) m_req = apply_mask(m_req, d);
      else if (a == 1) m_en = apply_mask(m_en, d);
      else if (a == 2) m_cfg = d & 3;
    end
    m_req = m_req | e;
    #1;
    pin_chk();
    @(negedge clk);
    wr_en = 0; evt = '0;
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    rd_addr = a[1:0];
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 req reset", 0, 0);
    rd("R1 en reset", 1, 0);
    rd("R1 cfg reset", 2, 2);
    chk("R1 irq_o reset", int'(irq_o), 0);
    chk("R1 irq_oe reset", int'(irq_oe), 0);

    step(0, 0, 0, 6'h08);
    rd("R2 receive latched", 0, 8'h08);
    step(0, 0, 0, 0);
    rd("R2 stays after pulse", 0, 8'h08);

    step(1, 1, 8'h88, 0);
    rd("R5 enable set", 1, 8'h08);
    chk("R7 active high pending", int'(irq_o), 1);
    chk("R8 open drain drives", int'(irq_oe), 1);

    step(1, 0, 8'h08, 0);
    rd("R3 clear receive", 0, 0);
    chk("R8 open drain released", int'(irq_oe), 0);

    step(1, 0, 8'h81, 0);
    rd("R4 81h sets low alert only", 0, 8'h01);
    chk("R7 masked source no irq", int'(irq_o), 0);

    step(1, 0, 8'hBF, 0);
    rd("R4 set all", 0, 8'h3F);
    step(1, 0, 8'h3F, 0);
    rd("R3 3Fh clears all", 0, 0);

    step(1, 0, 8'hC2, 0);
    rd("R10 bit6 ignored", 0, 8'h02);
    rd("R10 enable untouched", 1, 8'h08);
    rd("R10 cfg untouched", 2, 2);

    step(1, 0, 8'h22, 6'h20);
    rd("R6 event beats clear", 0, 8'h20);

    step(1, 2, 8'h01, 0);
    rd("R9 cfg readback", 2, 1);
    chk("R7 active low idle high", int'(irq_o), 1);
    chk("R8 push pull drives", int'(irq_oe), 1);
    step(1, 1, 8'hA0, 0);
    chk("R7 active low pending", int'(irq_o), 0);

    step(1, 2, 8'hFF, 0);
    rd("R9 cfg upper bits zero", 2, 3);
    rd("R9 address 3 reads zero", 3, 0);
    rd("R10 req after cfg write", 0, 8'h20);

    step(1, 1, 8'h3F, 0);
    rd("R5 enable clear all", 1, 0);

    for (int n = 0; n < 400; n++) begin
      int d = int'($urandom_range(0, 255));
      int a = int'($urandom_range(0, 3));
      int e = (($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 63)) : 0);
      bit we = ($urandom_range(0, 1) == 1);
      step(we, a, d, e);
      rd("R3 R4 random req", 0, m_req);
      rd("R5 random en", 1, m_en);
      rd("R9 random cfg", 2, m_cfg);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule